// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master DMA Engine for a Disk Channel

This block moves 16-bit words between a disk drive's data port and system memory without processor help. Software places a table of 8-byte descriptors in memory, programs the table address and transfer direction through a small 32-bit register block, and sets a run bit. The engine then reads descriptors one by one, each naming a buffer and its length, and services the drive's DMA requests until the descriptor flagged as final is used up.

The register block also carries an interrupt flag that is raised by the drive's interrupt line, an error flag, and two free scratch bits that software uses to record whether each drive can do DMA. Both flags are cleared by writing a one to them. Clearing the run bit while a transfer is in progress stops it after the word in flight.

Memory is reached through a simple request/acknowledge master port. It issues 32-bit reads for descriptor halves and 16-bit reads or writes for data. The drive side uses one-cycle read and write strobes together with a request and acknowledge pair.

Top module: `bmdma_engine`

## Requirements
- R1: Register word 0 shows the command byte in bits 7:0 and the status byte in bits 23:16, with all other bits zero. Word 1 shows the table pointer. Any other word reads as 32'hFFFFFFFF. After reset, words 0 and 1 read as zero.
- R2: A write to the command byte stores only bit 0 (run) and bit 3 (direction: 1 = drive to memory, 0 = memory to drive). Every other command bit reads back as zero.
- R3: Writing run = 1 while run is 0 sets status bit 0 (busy) and restarts the walk at the table pointer. Writing run = 1 while run is already 1 has no effect. Writing run = 0 while busy clears busy, and no further drive strobes follow.
- R4: Writing a one to status bit 1 (error) or status bit 2 (interrupt) clears that bit. Status bits 6:5 are plain read/write. The busy bit and bits 7, 4 and 3 ignore writes. The status byte is written only when byte enable 2 is set, and the command byte only when byte enable 0 is set.
- R5: A rising edge of drv_irq sets status bit 2 one cycle later. A level held high sets it only once.
- R6: The table pointer is stored per byte enable, and its bits 1:0 always read as zero.
- R7: A descriptor is two little-endian 32-bit words at pointer and pointer+4. The first word is the buffer address, with bit 0 ignored. In the second word, bits 15:1 give the byte count, bit 31 marks the final entry, and bits 30:16 and bit 0 are ignored. A count of zero means 65536 bytes.
- R8: The next descriptor is read, 8 bytes further on, only after the current count reaches zero.
- R9: In drive-to-memory mode, each word taken from the drive is written to memory at the buffer address, low byte at the lower address. The address then advances by 2, and exactly count/2 words go to each buffer.
- R10: In memory-to-drive mode, each 16-bit memory word, low byte from the lower address, is presented on drv_wdata with a one-cycle drv_wr_stb, in buffer order.
- R11: Words move only while drv_dmarq is high and busy is set. drv_dmack is high whenever a strobe is issued, and it is low when the engine is stalled with no request.
- R12: When the final descriptor's count reaches zero, busy clears. If the drive has stopped requesting, the error bit stays clear.
- R13: If drv_dmarq is still high once the final descriptor is exhausted, busy clears and the error bit is set.
- R14: A memory request stays asserted, with its address and write flag unchanged, until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte enables for a register write |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = 16-bit write, 0 = read |
| mem_wide | output | 1 | 1 = 32-bit descriptor read, 0 = 16-bit data access |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| drv_dmarq | input | 1 | Drive DMA request |
| drv_dmack | output | 1 | DMA acknowledge to the drive |
| drv_irq | input | 1 | Drive interrupt line |
| drv_rd_stb | output | 1 | One-cycle strobe taking drv_rdata |
| drv_rdata | input | 16 | Word from the drive |
| drv_wr_stb | output | 1 | One-cycle strobe presenting drv_wdata |
| drv_wdata | output | 16 | Word to the drive |

## Verification
Register reads are combinational and are sampled in the same cycle the index is set. A write is visible in the cycle after its clock edge. The interrupt flag is visible one cycle after the edge at which drv_irq is first seen high. A drive read strobe is taken at the edge where it is high. The matching memory write lands after one or more acknowledge cycles, and memory-to-drive strobes come one cycle after the memory acknowledge. Because memory latency is randomized, transfer results are not checked at fixed cycles. Instead the bench polls the busy bit, with a bound, and checks memory contents, strobe counts and flags only after busy has cleared or after a fixed stall window.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

   typedef enum logic [2:0] {
      S_RUN  = 3'd0,
      S_FA   = 3'd1,
      S_FC   = 3'd2,
      S_MW   = 3'd3,
      S_MR   = 3'd4,
      S_DW   = 3'd5,
      S_TAIL = 3'd6
   } eng_st_t;

   localparam int CMD_RUN = 0;
   localparam int CMD_DIR = 3;
   localparam int ST_BUSY = 0;
   localparam int ST_ERR  = 1;
   localparam int ST_IRQ  = 2;
   localparam int CNT_W   = 17;

endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
   import bmdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_AW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [3:0]        reg_be,
   output logic [31:0]       reg_rdata,
   input  logic              drv_irq,
   input  logic              done_i,
   input  logic              err_i,
   output logic              start_o,
   output logic              busy_o,
   output logic              dir_o,
   output logic [ADDR_W-1:0] tbl_o
);
   localparam int NWORDS = 1 << REG_AW;
   localparam int NLANES = ADDR_W / 8;

   logic              cmd_run, cmd_dir, st_busy, st_err, st_irq, irq_q;
   logic [1:0]        st_cap;
   logic [ADDR_W-1:0] tbl, tbl_nx;
   logic              sel_ctl, sel_tbl, run_rise, run_fall, irq_rise;
   logic [7:0]        cmd_byte, sta_byte;
   logic [31:0]       rword [NWORDS];

   assign sel_ctl  = reg_wr && (reg_addr == REG_AW'(0));
   assign sel_tbl  = reg_wr && (reg_addr == REG_AW'(1));
   assign run_rise = sel_ctl && reg_be[0] && reg_wdata[CMD_RUN] && !cmd_run;
   assign run_fall = sel_ctl && reg_be[0] && !reg_wdata[CMD_RUN] && cmd_run;
   assign irq_rise = drv_irq && !irq_q;

   for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
      assign tbl_nx[ln*8 +: 8] = (sel_tbl && reg_be[ln]) ? reg_wdata[ln*8 +: 8]
                                                         : tbl[ln*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_run <= 1'b0;
         cmd_dir <= 1'b0;
         st_busy <= 1'b0;
         st_err  <= 1'b0;
         st_irq  <= 1'b0;
         st_cap  <= 2'b00;
         irq_q   <= 1'b0;
         tbl     <= '0;
      end else begin
         irq_q <= drv_irq;
         tbl   <= {tbl_nx[ADDR_W-1:2], 2'b00};
         if (sel_ctl && reg_be[0]) begin
            cmd_run <= reg_wdata[CMD_RUN];
            cmd_dir <= reg_wdata[CMD_DIR];
         end
         if (run_rise)                 st_busy <= 1'b1;
         else if (run_fall || done_i)  st_busy <= 1'b0;
         if (err_i)                                          st_err <= 1'b1;
         else if (sel_ctl && reg_be[2] && reg_wdata[16+ST_ERR]) st_err <= 1'b0;
         if (irq_rise)                                       st_irq <= 1'b1;
         else if (sel_ctl && reg_be[2] && reg_wdata[16+ST_IRQ]) st_irq <= 1'b0;
         if (sel_ctl && reg_be[2]) st_cap <= reg_wdata[22:21];
      end
   end

   assign cmd_byte = {4'b0000, cmd_dir, 2'b00, cmd_run};
   assign sta_byte = {1'b0, st_cap, 2'b00, st_irq, st_err, st_busy};

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      if (w == 0) begin : g_ctl
         assign rword[w] = {8'h00, sta_byte, 8'h00, cmd_byte};
      end else if (w == 1) begin : g_tbl
         assign rword[w] = 32'(tbl);
      end else begin : g_none
         assign rword[w] = '1;
      end
   end

   assign reg_rdata = rword[reg_addr];
   assign start_o   = run_rise;
   assign busy_o    = st_busy;
   assign dir_o     = cmd_dir;
   assign tbl_o     = tbl;

   p_run_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ctl && reg_be[0] && reg_wdata[CMD_RUN] && !cmd_run) |=> st_busy);
   p_irq_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_irq) |=> st_irq);
   p_err_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
      err_i |=> st_err);

endmodule

// File: rtl/bmdma_core.sv
module bmdma_core
   import bmdma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              busy_i,
   input  logic              dir_i,
   input  logic [ADDR_W-1:0] tbl_i,
   output logic              done_o,
   output logic              err_o,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_wide,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic              drv_dmarq,
   output logic              drv_dmack,
   output logic              drv_rd_stb,
   input  logic [15:0]       drv_rdata,
   output logic              drv_wr_stb,
   output logic [15:0]       drv_wdata
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << 16;
   localparam logic [CNT_W-1:0] STEP     = CNT_W'(2);

   eng_st_t           st;
   logic [ADDR_W-1:0] dptr, baddr;
   logic [CNT_W-1:0]  rem;
   logic              last;
   logic [15:0]       word;
   logic              go;
   logic              unused_bits;

   assign unused_bits = ^{mem_rdata[30:16], mem_rdata[0]};
   assign go = busy_i && drv_dmarq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_RUN;
         dptr  <= '0;
         baddr <= '0;
         rem   <= '0;
         last  <= 1'b0;
         word  <= '0;
      end else begin
         if (start_i) begin
            dptr <= tbl_i;
            rem  <= '0;
            last <= 1'b0;
         end
         unique case (st)
            S_RUN: if (go) begin
               if (rem == '0)  st <= S_FA;
               else if (dir_i) begin
                  word <= drv_rdata;
                  st   <= S_MW;
               end else st <= S_MR;
            end
            S_FA: if (mem_ack) begin
               baddr <= {mem_rdata[ADDR_W-1:1], 1'b0};
               dptr  <= dptr + ADDR_W'(4);
               st    <= busy_i ? S_FC : S_RUN;
            end
            S_FC: if (mem_ack) begin
               last <= mem_rdata[31];
               rem  <= (mem_rdata[15:1] == '0) ? FULL_CNT
                                               : {1'b0, mem_rdata[15:1], 1'b0};
               dptr <= dptr + ADDR_W'(4);
               st   <= S_RUN;
            end
            S_MW: if (mem_ack) begin
               baddr <= baddr + ADDR_W'(2);
               rem   <= rem - STEP;
               st    <= (rem == STEP && last) ? S_TAIL : S_RUN;
            end
            S_MR: if (mem_ack) begin
               word  <= mem_rdata[15:0];
               baddr <= baddr + ADDR_W'(2);
               rem   <= rem - STEP;
               st    <= S_DW;
            end
            S_DW:    st <= (rem == '0 && last) ? S_TAIL : S_RUN;
            S_TAIL:  st <= S_RUN;
            default: st <= S_RUN;
         endcase
      end
   end

   assign mem_req    = (st == S_FA) || (st == S_FC) || (st == S_MW) || (st == S_MR);
   assign mem_wide   = (st == S_FA) || (st == S_FC);
   assign mem_we     = (st == S_MW);
   assign mem_addr   = mem_wide ? dptr : baddr;
   assign mem_wdata  = word;
   assign drv_wdata  = word;
   assign drv_wr_stb = (st == S_DW);
   assign drv_rd_stb = (st == S_RUN) && go && (rem != '0) && dir_i;
   assign drv_dmack  = (st != S_RUN) || go;
   assign done_o     = (st == S_TAIL);
   assign err_o      = (st == S_TAIL) && drv_dmarq;

   p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   p_fetch_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_wide && st == S_FA) |-> (rem == '0));
   p_word_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_wide) |-> !mem_addr[0]);

endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
   import bmdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_AW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [3:0]        reg_be,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_wide,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic              drv_dmarq,
   output logic              drv_dmack,
   input  logic              drv_irq,
   output logic              drv_rd_stb,
   input  logic [15:0]       drv_rdata,
   output logic              drv_wr_stb,
   output logic [15:0]       drv_wdata
);
   initial begin
      assert (ADDR_W >= 17 && ADDR_W <= 32 && ADDR_W % 8 == 0)
         else $error("ADDR_W must be 24 or 32");
      assert (REG_AW >= 1 && REG_AW <= 8) else $error("REG_AW out of range");
   end

   logic              start_p, busy, dir, done_p, err_p;
   logic [ADDR_W-1:0] tbl;

   bmdma_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
      .drv_irq(drv_irq), .done_i(done_p), .err_i(err_p),
      .start_o(start_p), .busy_o(busy), .dir_o(dir), .tbl_o(tbl)
   );

   bmdma_core #(.ADDR_W(ADDR_W)) u_core (
      .clk(clk), .rst_n(rst_n), .start_i(start_p), .busy_i(busy), .dir_i(dir),
      .tbl_i(tbl), .done_o(done_p), .err_o(err_p),
      .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .drv_dmarq(drv_dmarq), .drv_dmack(drv_dmack), .drv_rd_stb(drv_rd_stb),
      .drv_rdata(drv_rdata), .drv_wr_stb(drv_wr_stb), .drv_wdata(drv_wdata)
   );

   p_strobe_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_rd_stb || drv_wr_stb) |-> drv_dmack);
   p_final_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_p && !start_p) |=> !busy);

endmodule

// File: tb/bmdma_engine_tb.sv
module bmdma_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_wide, mem_ack;
   logic [31:0] mem_addr, mem_rdata;
   logic [15:0] mem_wdata, drv_rdata, drv_wdata;
   logic        drv_dmarq, drv_dmack, drv_rd_stb, drv_wr_stb;
   logic        drv_irq = 1'b0;

   int          total = 0, bad = 0;
   int          xfer_cnt = 0, wide_cnt = 0, rq_lim = 0;
   logic        rq_en = 1'b0;
   logic [1:0]  lat = 2'd0;
   logic [7:0]  mb [0:4095];
   logic [15:0] sink [0:63];

   always #5 clk = ~clk;

   bmdma_engine #(.ADDR_W(32), .REG_AW(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .drv_dmarq(drv_dmarq), .drv_dmack(drv_dmack), .drv_irq(drv_irq),
      .drv_rd_stb(drv_rd_stb), .drv_rdata(drv_rdata), .drv_wr_stb(drv_wr_stb),
      .drv_wdata(drv_wdata)
   );

   function automatic logic [15:0] src_word(input int i);
      logic [31:0] t;
      t = i * 32'h0307;
      return t[15:0] ^ 16'hC35A;
   endfunction

   assign drv_dmarq = rq_en && (xfer_cnt < rq_lim);
   assign drv_rdata = src_word(xfer_cnt);

   always @(posedge clk) begin
      if (drv_rd_stb || drv_wr_stb) begin
         if (drv_wr_stb) sink[xfer_cnt[5:0]] <= drv_wdata;
         xfer_cnt <= xfer_cnt + 1;
      end
   end

   always @(posedge clk) begin
      logic [11:0] a;
      mem_ack <= 1'b0;
      if (rst_n && mem_req && !mem_ack) begin
         if (lat != 2'd0) lat <= lat - 2'd1;
         else begin
            a = mem_addr[11:0];
            mem_ack <= 1'b1;
            lat <= 2'($urandom % 3);
            if (mem_we) begin
               mb[a] <= mem_wdata[7:0];
               mb[a+12'd1] <= mem_wdata[15:8];
            end else if (mem_wide) begin
               mem_rdata <= {mb[a+12'd3], mb[a+12'd2], mb[a+12'd1], mb[a]};
               wide_cnt <= wide_cnt + 1;
            end else begin
               mem_rdata <= {16'h0000, mb[a+12'd1], mb[a]};
            end
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = 4'h0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put32(input int a, input logic [31:0] v);
      mb[a] = v[7:0]; mb[a+1] = v[15:8]; mb[a+2] = v[23:16]; mb[a+3] = v[31:24];
   endtask

   function automatic logic [31:0] get16(input int a);
      return {16'h0000, mb[a+1], mb[a]};
   endfunction

   task automatic run_wait(output logic [31:0] s);
      for (int i = 0; i < 3000; i++) begin
         rd(2'd0, s);
         if (!s[16]) break;
      end
   endtask

   task automatic zero(input int a, input int n);
      for (int i = 0; i < n; i++) mb[a+i] = 8'h00;
   endtask

   logic [31:0] s;
   int base, w0, idx, nd, tot;
   int nw [3];

   initial begin : main
      void'($urandom(32'd1234));
      for (int i = 0; i < 4096; i++) mb[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state and map
      rd(2'd0, s); chk("R1", "word0 after reset", s, 32'h0);
      rd(2'd1, s); chk("R1", "word1 after reset", s, 32'h0);
      rd(2'd2, s); chk("R1", "unmapped word2", s, 32'hFFFF_FFFF);
      rd(2'd3, s); chk("R1", "unmapped word3", s, 32'hFFFF_FFFF);
      chk("R11", "dmack idle", {31'd0, drv_dmack}, 32'd0);

      // command masking
      wr(2'd0, 32'h0000_00FE, 4'b0001);
      rd(2'd0, s); chk("R2", "command mask", s, 32'h0000_0008);
      wr(2'd0, 32'h0000_0000, 4'b0001);

      // table pointer
      wr(2'd1, 32'h1234_5677, 4'b1111);
      rd(2'd1, s); chk("R6", "pointer low bits", s, 32'h1234_5674);
      wr(2'd1, 32'hAAAA_AAAA, 4'b0010);
      rd(2'd1, s); chk("R6", "pointer byte enable", s, 32'h1234_AA74);

      // status write behaviour
      wr(2'd0, 32'h00FF_00FF, 4'b0100);
      rd(2'd0, s); chk("R4", "status writable bits only", s, 32'h0060_0000);
      wr(2'd0, 32'h0000_0000, 4'b0100);
      rd(2'd0, s); chk("R4", "scratch bits cleared", s, 32'h0);

      // interrupt edge and clear
      @(negedge clk); drv_irq = 1'b1;
      @(negedge clk);
      rd(2'd0, s); chk("R5", "irq set on edge", s, 32'h0004_0000);
      wr(2'd0, 32'h0004_0000, 4'b0100);
      repeat (3) @(negedge clk);
      rd(2'd0, s); chk("R5", "held level no reset of flag", s, 32'h0);
      drv_irq = 1'b0;

      // two-descriptor drive-to-memory transfer
      put32(32'h100, 32'h0000_0401); put32(32'h104, 32'h0000_0006);
      put32(32'h108, 32'h0000_0600); put32(32'h10C, 32'h8000_0004);
      zero(32'h400, 16); zero(32'h600, 16);
      wr(2'd1, 32'h0000_0100, 4'b1111);
      base = xfer_cnt; w0 = wide_cnt; rq_lim = base + 5; rq_en = 1'b1;
      wr(2'd0, 32'h0000_0009, 4'b0001);
      run_wait(s);
      chk("R12", "final clears busy, no error", s, 32'h0000_0009);
      for (int i = 0; i < 3; i++)
         chk("R9", "buffer0 word", get16(32'h400 + 2*i), {16'h0, src_word(base + i)});
      for (int i = 0; i < 2; i++)
         chk("R9", "buffer1 word", get16(32'h600 + 2*i), {16'h0, src_word(base + 3 + i)});
      chk("R9", "byte past buffer0", {24'h0, mb[32'h406]}, 32'h0);
      chk("R8", "descriptor reads", wide_cnt - w0, 32'd4);
      chk("R11", "strobe count", xfer_cnt - base, 32'd5);

      // run written again while already set
      base = xfer_cnt; rq_lim = base + 4;
      wr(2'd0, 32'h0000_0009, 4'b0001);
      repeat (20) @(negedge clk);
      chk("R3", "no restart without 0-to-1", xfer_cnt - base, 32'd0);
      rd(2'd0, s); chk("R3", "busy stays clear", s, 32'h0000_0009);
      rq_lim = xfer_cnt;
      wr(2'd0, 32'h0, 4'b0001);

      // memory-to-drive transfer
      put32(32'h180, 32'h0000_0800); put32(32'h184, 32'h8000_0008);
      for (int i = 0; i < 8; i++) mb[32'h800 + i] = 8'($urandom);
      wr(2'd1, 32'h0000_0180, 4'b1111);
      base = xfer_cnt; rq_lim = base + 4;
      wr(2'd0, 32'h0000_0001, 4'b0001);
      run_wait(s);
      chk("R12", "mem-to-drive done", s, 32'h0000_0001);
      for (int i = 0; i < 4; i++)
         chk("R10", "drive word", {16'h0, sink[(base + i) % 64]}, get16(32'h800 + 2*i));
      wr(2'd0, 32'h0, 4'b0001);

      // overrun error
      put32(32'h1C0, 32'h0000_0900); put32(32'h1C4, 32'h8000_0008);
      wr(2'd1, 32'h0000_01C0, 4'b1111);
      base = xfer_cnt; rq_lim = base + 6;
      wr(2'd0, 32'h0000_0009, 4'b0001);
      run_wait(s);
      chk("R13", "error on overrun", s, 32'h0002_0009);
      chk("R13", "words before stop", xfer_cnt - base, 32'd4);
      wr(2'd0, 32'h0002_0008, 4'b0101);
      rd(2'd0, s); chk("R4", "error write-1-clear", s, 32'h0000_0008);
      rq_lim = xfer_cnt;

      // stall then abort
      put32(32'h380, 32'h0000_0E00); put32(32'h384, 32'h8000_0040);
      wr(2'd1, 32'h0000_0380, 4'b1111);
      base = xfer_cnt; rq_lim = base + 3;
      wr(2'd0, 32'h0000_0009, 4'b0001);
      repeat (60) @(negedge clk);
      rd(2'd0, s); chk("R11", "stalled still busy", s, 32'h0001_0009);
      chk("R11", "stall after request drop", xfer_cnt - base, 32'd3);
      chk("R11", "dmack low while stalled", {31'd0, drv_dmack}, 32'd0);
      wr(2'd0, 32'h0000_0008, 4'b0001);
      rd(2'd0, s); chk("R3", "abort clears busy", s, 32'h0000_0008);
      rq_lim = base + 10;
      repeat (40) @(negedge clk);
      chk("R3", "no strobes after abort", xfer_cnt - base, 32'd3);
      rq_lim = xfer_cnt;

      // zero count means 64 KiB
      zero(32'hA00, 16);
      put32(32'h3C0, 32'h0000_0A00); put32(32'h3C4, 32'h0000_0000);
      put32(32'h3C8, 32'h0000_0B00); put32(32'h3CC, 32'h8000_0002);
      wr(2'd1, 32'h0000_03C0, 4'b1111);
      base = xfer_cnt; w0 = wide_cnt; rq_lim = base + 5;
      wr(2'd0, 32'h0000_0009, 4'b0001);
      repeat (80) @(negedge clk);
      chk("R7", "zero count not refetched", wide_cnt - w0, 32'd2);
      rd(2'd0, s); chk("R7", "zero count still busy", s, 32'h0001_0009);
      chk("R9", "fifth word in large buffer", get16(32'hA08), {16'h0, src_word(base + 4)});
      wr(2'd0, 32'h0000_0008, 4'b0001);
      rq_lim = xfer_cnt;

      // randomized descriptor chains with junk in ignored bits
      for (int it = 0; it < 4; it++) begin
         wr(2'd0, 32'h0, 4'b0001);
         zero(32'hC00, 192);
         nd = 1 + int'($urandom % 3);
         tot = 0;
         for (int k = 0; k < nd; k++) begin
            nw[k] = 1 + int'($urandom % 8);
            put32(32'h300 + 8*k, (32'hC00 + 32'h40*k) | ($urandom & 32'h1));
            put32(32'h304 + 8*k, (32'(nw[k]) * 2) | ($urandom & 32'h7FFF_0001)
                                 | ((k == nd - 1) ? 32'h8000_0000 : 32'h0));
            tot += nw[k];
         end
         wr(2'd1, 32'h300 | ($urandom & 32'h3), 4'b1111);
         base = xfer_cnt; rq_lim = base + tot;
         wr(2'd0, 32'h0000_0009, 4'b0001);
         run_wait(s);
         chk("R12", "random chain status", s, 32'h0000_0009);
         idx = base;
         for (int k = 0; k < nd; k++) begin
            for (int i = 0; i < nw[k]; i++) begin
               chk("R9", "random word", get16(32'hC00 + 32'h40*k + 2*i), {16'h0, src_word(idx)});
               idx++;
            end
            chk("R7", "count extent", {24'h0, mb[32'hC00 + 32'h40*k + 2*nw[k]]}, 32'h0);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule